// File: doc/BRIEF.md
# Symmetric Horizontal Video FIR Filter

This block filters a stream of 12-bit two's complement pixels along a video line. It has sixteen multipliers. When the coefficients are symmetric, the two pixels that share a coefficient are added together before the multiply. This lets the sixteen multipliers cover up to thirty-two taps. A two-bit mode input sets how the datapath is used. It can run as one long symmetric filter, as two independent symmetric filters, as one asymmetric filter, or as two independent asymmetric filters. In the two-filter modes, a second pixel input feeds the second filter.

Each delay stage holds a programmable number of samples, from 1 to 16. Because of this, a stream that carries several time-multiplexed channels is filtered without being split apart: each tap sees only samples of its own channel. The sum is kept at full precision. It is then rounded at a programmable bit position, clamped between programmable lower and upper limits, and delivered as a 16-bit result. Results come out at one per accepted sample, with a valid flag alongside.

Top module: `vidfir_sym`

## Requirements
- R1: While `rstN` is low, `outValid`, `outA` and `outB` are 0, and the delay lines and coefficient registers are cleared to 0.
- R2: A sample accepted at rising edge k (`inValid` high) produces `outValid` high and its results after rising edge k+3. No result appears without an accepted sample. Both outputs hold their value while `outValid` is low.
- R3: Mode 0 (single symmetric, 32 taps): outA = sum over i=0..15 of c[i]*(x[m-iD] + x[m-(31-i)D]), where x is the `dinA` sample sequence and m is the newest sample.
- R4: Mode 1 (two symmetric filters, 16 taps each): outA = sum over i=0..7 of c[i]*(x[m-iD] + x[m-(15-i)D]) on `dinA`. outB applies c[8+j] for j=0..7 in the same way to the `dinB` sequence.
- R5: Mode 2 (single asymmetric, 16 taps): outA = sum over i=0..15 of c[i]*x[m-iD].
- R6: Mode 3 (two asymmetric filters, 8 taps each): outA = sum over i=0..7 of c[i]*x[m-iD]. outB = sum over j=0..7 of c[8+j]*y[m-jD], where y is the `dinB` sequence.
- R7: The tap spacing is D = `ilDepth`+1 accepted samples, for D from 1 to 16. Tap 0 is always the newest sample.
- R8: Rounding with shift s = `rndShift`: the sum plus 2^(s-1) (nothing when s = 0) is shifted right arithmetically by s.
- R9: The rounded value is clamped to [`limMin`, `limMax`], both 16-bit signed, instead of wrapping.
- R10: Cycles with `inValid` low do not advance the delay lines. `dinA` and `dinB` are ignored on those cycles.
- R11: In the single-filter modes (0 and 2), `outB` is 0 on every result.
- R12: The internal sum never wraps. Full-scale pixels times full-scale coefficients give the exact sum before rounding and limiting.
- R13: Coefficient i is written from `coefData` at a rising edge with `coefWe` high and `coefAddr` = i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 single symmetric, 1 dual symmetric, 2 single asymmetric, 3 dual asymmetric |
| ilDepth | input | 4 | Interleave depth minus one (tap spacing D = value+1) |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | 4 | Coefficient index 0..15 |
| coefData | input | 12 | Coefficient value, two's complement |
| rndShift | input | 5 | Rounding bit position |
| limMin | input | 16 | Lower clamp limit, signed |
| limMax | input | 16 | Upper clamp limit, signed |
| inValid | input | 1 | A sample is present on the pixel inputs |
| dinA | input | 12 | Pixel input, first filter |
| dinB | input | 12 | Pixel input, second filter (dual modes) |
| outValid | output | 1 | Results valid |
| outA | output | 16 | Result of the single filter or of the first filter |
| outB | output | 16 | Result of the second filter; 0 in single modes |

## Verification
There are three register stages: the delay line, the products and the sums. The clamped output register follows them. Each result therefore appears three rising edges after the edge that accepted its sample, and the bench records that due cycle when it drives the sample. The bench drives and samples on the falling edge. A scoreboard compares each `outValid` pulse against the oldest pending expectation and checks that it arrived exactly on its due cycle. At the end of every scenario, the bench waits a few cycles and checks that no expected result is still pending.

// File: rtl/vidfir_pkg.sv
`timescale 1ns/1ps
package vidfir_pkg;

  typedef enum logic [1:0] {
    MODE_SYM_LONG  = 2'd0,
    MODE_SYM_PAIR  = 2'd1,
    MODE_ASYM_LONG = 2'd2,
    MODE_ASYM_PAIR = 2'd3
  } firMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // advance delay lines
    logic prodEn;   // load product registers
    logic sumEn;    // load accumulator registers
    logic outEn;    // load rounded, clamped outputs
    logic dual;     // two independent filters
    logic asym;     // no pre-add
  } firStrobe_t;

endpackage

// File: rtl/vidfir_ctrl.sv
`timescale 1ns/1ps
module vidfir_ctrl
  import vidfir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] mode,
  output firStrobe_t stb,
  output logic       outValid
);

  logic [2:0] vPipe;
  firMode_e   modeE;

  assign modeE = firMode_e'(mode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe    <= '0;
      outValid <= 1'b0;
    end else begin
      vPipe    <= {vPipe[1:0], inValid};
      outValid <= vPipe[2];
    end
  end

  always_comb begin
    stb.shiftEn = inValid;
    stb.prodEn  = vPipe[0];
    stb.sumEn   = vPipe[1];
    stb.outEn   = vPipe[2];
    stb.dual    = (modeE == MODE_SYM_PAIR) || (modeE == MODE_ASYM_PAIR);
    stb.asym    = (modeE == MODE_ASYM_LONG) || (modeE == MODE_ASYM_PAIR);
  end

endmodule

// File: rtl/vidfir_dp.sv
`timescale 1ns/1ps
module vidfir_dp
  import vidfir_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int COEF_W    = 12,
  parameter int OUT_W     = 16,
  parameter int HALF_TAPS = 16,
  parameter int MAX_IL    = 16,
  localparam int IL_W     = $clog2(MAX_IL),
  localparam int CA_W     = $clog2(HALF_TAPS),
  localparam int PRE_W    = DATA_W + 1,
  localparam int PROD_W   = PRE_W + COEF_W,
  localparam int ACC_W    = PROD_W + $clog2(2 * HALF_TAPS) + 1,
  localparam int SH_W     = $clog2(ACC_W)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  firStrobe_t               stb,
  input  logic signed [DATA_W-1:0] dinA,
  input  logic signed [DATA_W-1:0] dinB,
  input  logic [IL_W-1:0]          ilDepth,
  input  logic                     coefWe,
  input  logic [CA_W-1:0]          coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  input  logic [SH_W-1:0]          rndShift,
  input  logic signed [OUT_W-1:0]  limMin,
  input  logic signed [OUT_W-1:0]  limMax,
  output logic signed [OUT_W-1:0]  outA,
  output logic signed [OUT_W-1:0]  outB
);

  localparam int H2 = HALF_TAPS / 2;

  // ---------------- coefficient bank ----------------
  logic signed [COEF_W-1:0] coefReg [HALF_TAPS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HALF_TAPS; i++) coefReg[i] <= '0;
    end else if (coefWe) begin
      coefReg[coefAddr] <= coefData;
    end
  end

  // ---------------- delay lines ----------------
  // line 0 feeds filter A; line 1 is either the tail of line 0 or the B input
  logic signed [DATA_W-1:0] lineMem [2][HALF_TAPS][MAX_IL];
  logic signed [DATA_W-1:0] tapA    [HALF_TAPS];
  logic signed [DATA_W-1:0] tapB    [HALF_TAPS];
  logic signed [DATA_W-1:0] stageIn [2][HALF_TAPS];

  always_comb begin
    tapA[0] = lineMem[0][0][0];
    tapB[0] = lineMem[1][0][stb.dual ? IL_W'(0) : ilDepth];
    for (int k = 1; k < HALF_TAPS; k++) begin
      tapA[k] = lineMem[0][k][ilDepth];
      tapB[k] = lineMem[1][k][ilDepth];
    end
  end

  always_comb begin
    stageIn[0][0] = dinA;
    stageIn[1][0] = stb.dual ? dinB : tapA[HALF_TAPS-1];
    for (int k = 1; k < HALF_TAPS; k++) begin
      stageIn[0][k] = tapA[k-1];
      stageIn[1][k] = tapB[k-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < 2; l++)
        for (int k = 0; k < HALF_TAPS; k++)
          for (int j = 0; j < MAX_IL; j++)
            lineMem[l][k][j] <= '0;
    end else if (stb.shiftEn) begin
      for (int l = 0; l < 2; l++)
        for (int k = 0; k < HALF_TAPS; k++) begin
          lineMem[l][k][0] <= stageIn[l][k];
          for (int j = 1; j < MAX_IL; j++)
            lineMem[l][k][j] <= lineMem[l][k][j-1];
        end
    end
  end

  // ---------------- pre-add and multiply ----------------
  logic signed [PROD_W-1:0] prodVec [HALF_TAPS];

  for (genvar i = 0; i < HALF_TAPS; i++) begin : g_mac
    logic signed [DATA_W-1:0] opP;
    logic signed [DATA_W-1:0] opQ;
    logic signed [PRE_W-1:0]  preSum;
    logic signed [PROD_W-1:0] prodQ;

    if (i < H2) begin : g_lo
      always_comb begin
        opP = tapA[i];
        if (stb.asym)      opQ = '0;
        else if (stb.dual) opQ = tapA[HALF_TAPS-1-i];
        else               opQ = tapB[HALF_TAPS-1-i];
      end
    end else begin : g_hi
      always_comb begin
        opP = stb.dual ? tapB[i-H2] : tapA[i];
        if (stb.asym)      opQ = '0;
        else if (stb.dual) opQ = tapB[HALF_TAPS-1-(i-H2)];
        else               opQ = tapB[HALF_TAPS-1-i];
      end
    end

    assign preSum = {opP[DATA_W-1], opP} + {opQ[DATA_W-1], opQ};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           prodQ <= '0;
      else if (stb.prodEn) prodQ <= preSum * coefReg[i];
    end

    assign prodVec[i] = prodQ;
  end

  // ---------------- accumulation ----------------
  logic signed [ACC_W-1:0] sumLo, sumHi, accA, accB;
  logic                    dualS;

  always_comb begin
    sumLo = '0;
    sumHi = '0;
    for (int i = 0; i < H2; i++)
      sumLo = sumLo + ACC_W'(prodVec[i]);
    for (int i = H2; i < HALF_TAPS; i++)
      sumHi = sumHi + ACC_W'(prodVec[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accA  <= '0;
      accB  <= '0;
      dualS <= 1'b0;
    end else if (stb.sumEn) begin
      accA  <= stb.dual ? sumLo : sumLo + sumHi;
      accB  <= stb.dual ? sumHi : '0;
      dualS <= stb.dual;
    end
  end

  // ---------------- round and limit ----------------
  function automatic logic signed [OUT_W-1:0] roundLimit(
    input logic signed [ACC_W-1:0] acc,
    input logic [SH_W-1:0]         sh,
    input logic signed [OUT_W-1:0] lo,
    input logic signed [OUT_W-1:0] hi
  );
    logic signed [ACC_W:0] biased;
    logic signed [ACC_W:0] shifted;
    logic signed [ACC_W:0] loX;
    logic signed [ACC_W:0] hiX;
    biased = {acc[ACC_W-1], acc};
    if (sh != '0)
      biased = biased + ((ACC_W+1)'(1) << (sh - SH_W'(1)));
    shifted = biased >>> sh;
    loX = {{(ACC_W+1-OUT_W){lo[OUT_W-1]}}, lo};
    hiX = {{(ACC_W+1-OUT_W){hi[OUT_W-1]}}, hi};
    if (shifted > hiX)      shifted = hiX;
    else if (shifted < loX) shifted = loX;
    return shifted[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outA <= '0;
      outB <= '0;
    end else if (stb.outEn) begin
      outA <= roundLimit(accA, rndShift, limMin, limMax);
      outB <= dualS ? roundLimit(accB, rndShift, limMin, limMax) : '0;
    end
  end

endmodule

// File: rtl/vidfir_sym.sv
`timescale 1ns/1ps
module vidfir_sym
  import vidfir_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int COEF_W    = 12,
  parameter int OUT_W     = 16,
  parameter int HALF_TAPS = 16,
  parameter int MAX_IL    = 16,
  localparam int IL_W     = $clog2(MAX_IL),
  localparam int CA_W     = $clog2(HALF_TAPS),
  localparam int SH_W     = $clog2(DATA_W + COEF_W + 1 + $clog2(2 * HALF_TAPS) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [IL_W-1:0]   ilDepth,
  input  logic              coefWe,
  input  logic [CA_W-1:0]   coefAddr,
  input  logic [COEF_W-1:0] coefData,
  input  logic [SH_W-1:0]   rndShift,
  input  logic [OUT_W-1:0]  limMin,
  input  logic [OUT_W-1:0]  limMax,
  input  logic              inValid,
  input  logic [DATA_W-1:0] dinA,
  input  logic [DATA_W-1:0] dinB,
  output logic              outValid,
  output logic [OUT_W-1:0]  outA,
  output logic [OUT_W-1:0]  outB
);

  firStrobe_t stb;

  vidfir_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .mode     (mode),
    .stb      (stb),
    .outValid (outValid)
  );

  vidfir_dp #(
    .DATA_W    (DATA_W),
    .COEF_W    (COEF_W),
    .OUT_W     (OUT_W),
    .HALF_TAPS (HALF_TAPS),
    .MAX_IL    (MAX_IL)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dinA     (dinA),
    .dinB     (dinB),
    .ilDepth  (ilDepth),
    .coefWe   (coefWe),
    .coefAddr (coefAddr),
    .coefData (coefData),
    .rndShift (rndShift),
    .limMin   (limMin),
    .limMax   (limMax),
    .outA     (outA),
    .outB     (outB)
  );

endmodule

// File: rtl/vidfir_sym_chk.sv
`timescale 1ns/1ps
module vidfir_sym_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic [OUT_W-1:0] limMin,
  input logic [OUT_W-1:0] limMax,
  input logic             inValid,
  input logic             outValid,
  input logic [OUT_W-1:0] outA,
  input logic [OUT_W-1:0] outB
);

  // R1: reset clears the result outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |-> (!outValid && outA == '0 && outB == '0));

  // R2: every result traces back to a sample accepted three edges earlier
  p_valid_origin_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 4));

  // R2: every accepted sample yields a result
  p_valid_due_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid, 4) && $past(rstN, 4) && $past(rstN, 3) && $past(rstN, 2) && $past(rstN, 1))
    |-> outValid);

  // R2: outputs hold between results
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outA) && $stable(outB)));

  // R9: result lies within the limits
  p_limit_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $stable(limMin) && $stable(limMax) && ($signed(limMin) <= $signed(limMax)))
    |-> (($signed(outA) >= $signed(limMin)) && ($signed(outA) <= $signed(limMax))));

  // R11: single-filter modes leave the second output at zero
  p_single_b_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !mode[0] && $stable(mode) && ($past(mode, 2) == mode)) |-> (outB == '0));

endmodule

bind vidfir_sym vidfir_sym_chk #(.OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .mode     (mode),
  .limMin   (limMin),
  .limMax   (limMax),
  .inValid  (inValid),
  .outValid (outValid),
  .outA     (outA),
  .outB     (outB)
);

// File: tb/vidfir_sym_bench.sv
`timescale 1ns/1ps
module vidfir_sym_bench;

  localparam int HT = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic [1:0]  mode = '0;
  logic [3:0]  ilDepth = '0;
  logic        coefWe = 1'b0;
  logic [3:0]  coefAddr = '0;
  logic [11:0] coefData = '0;
  logic [4:0]  rndShift = '0;
  logic [15:0] limMin = 16'h8000;
  logic [15:0] limMax = 16'h7fff;
  logic        inValid = 1'b0;
  logic [11:0] dinA = '0;
  logic [11:0] dinB = '0;
  logic        outValid;
  logic [15:0] outA, outB;

  vidfir_sym u_vidfir_sym (
    .clk(clk), .rstN(rstN), .mode(mode), .ilDepth(ilDepth),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .rndShift(rndShift), .limMin(limMin), .limMax(limMax),
    .inValid(inValid), .dinA(dinA), .dinB(dinB),
    .outValid(outValid), .outA(outA), .outB(outB)
  );

  always #2.5 clk = ~clk;

  int cycCnt = 0;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  int     histA [1024];
  int     histB [1024];
  int     nSamp = 0;
  int     coefM [HT];
  longint qA [$];
  longint qB [$];
  int     qDue [$];
  int     nChk = 0;
  int     nFail = 0;
  string  curReq = "R1";
  bit     finished = 1'b0;

  task automatic reportFail(string req, string what, longint act, longint exp);
    nFail++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  task automatic check(string req, string what, longint act, longint exp);
    nChk++;
    if (act != exp) reportFail(req, what, act, exp);
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  function automatic longint xa(int idx);
    return (idx < 0) ? 0 : longint'(histA[idx]);
  endfunction
  function automatic longint xb(int idx);
    return (idx < 0) ? 0 : longint'(histB[idx]);
  endfunction

  // R8 rounding and R9 limiting
  function automatic longint roundLim(longint v);
    int s = int'(rndShift);
    longint lo = longint'($signed(limMin));
    longint hi = longint'($signed(limMax));
    if (s > 0) v = v + (longint'(1) <<< (s - 1));
    v = v >>> s;
    if (v > hi) v = hi;
    else if (v < lo) v = lo;
    return v;
  endfunction

  task automatic calcExp(output longint eA, output longint eB);
    int m = nSamp - 1;
    int d = int'(ilDepth) + 1;
    longint lo = 0, hi = 0, p, q;
    for (int i = 0; i < HT; i++) begin
      bit up;
      int j;
      up = (i >= HT/2);
      j  = i - HT/2;
      case (mode)
        2'd0: begin p = xa(m - i*d); q = xa(m - (2*HT-1-i)*d); end          // R3
        2'd1: if (!up) begin p = xa(m - i*d); q = xa(m - (HT-1-i)*d); end   // R4
              else begin p = xb(m - j*d); q = xb(m - (HT-1-j)*d); end
        2'd2: begin p = xa(m - i*d); q = 0; end                              // R5
        default: begin p = up ? xb(m - j*d) : xa(m - i*d); q = 0; end       // R6
      endcase
      if (up) hi += longint'(coefM[i]) * (p + q);
      else    lo += longint'(coefM[i]) * (p + q);
    end
    if (mode[0]) begin eA = roundLim(lo); eB = roundLim(hi); end
    else begin eA = roundLim(lo + hi); eB = 0; end   // R11
  endtask

  // ---------------- scoreboard ----------------
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (qDue.size() > 0 && cycCnt > qDue[0]) begin
        nChk++;
        reportFail("R2", "missing result", cycCnt, qDue[0]);
        void'(qA.pop_front()); void'(qB.pop_front()); void'(qDue.pop_front());
      end
      if (outValid) begin
        if (qDue.size() == 0) begin
          nChk++;
          reportFail("R2", "unexpected outValid", 1, 0);
        end else begin
          longint ea, eb;
          int due;
          ea = qA.pop_front(); eb = qB.pop_front(); due = qDue.pop_front();
          check("R2", "latency cycle", cycCnt, due);
          check(curReq, "outA", longint'($signed(outA)), ea);
          check(curReq, "outB", longint'($signed(outB)), eb);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pushSample(int a, int b);
    longint eA, eB;
    dinA = a[11:0];
    dinB = b[11:0];
    inValid = 1'b1;
    histA[nSamp] = a;
    histB[nSamp] = b;
    nSamp++;
    calcExp(eA, eB);
    qA.push_back(eA);
    qB.push_back(eB);
    qDue.push_back(cycCnt + 4);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // R10: idle cycles with garbage on the pixel inputs
  task automatic idleGap(int n);
    for (int g = 0; g < n; g++) begin
      dinA = 12'h5a5 + 12'(g);
      dinB = 12'ha3c - 12'(g);
      inValid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
    check("R2", "pending results after drain", qDue.size(), 0);
  endtask

  task automatic doReset();
    inValid = 1'b0;
    coefWe  = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "outValid in reset", outValid, 0);
    check("R1", "outA in reset", outA, 0);
    check("R1", "outB in reset", outB, 0);
    rstN = 1'b1;
    nSamp = 0;
    qA.delete(); qB.delete(); qDue.delete();
    for (int i = 0; i < HT; i++) coefM[i] = 0;
    @(negedge clk);
  endtask

  // R13: coefficient writes by index
  task automatic loadCoefs(int seed, int scale);
    for (int i = 0; i < HT; i++) begin
      int c;
      c = ((i * 53 + seed * 29) % (2 * scale + 1)) - scale;
      coefM[i] = c;
      coefWe   = 1'b1;
      coefAddr = 4'(i);
      coefData = c[11:0];
      @(negedge clk);
    end
    coefWe = 1'b0;
  endtask

  task automatic loadFlat(int c);
    for (int i = 0; i < HT; i++) begin
      coefM[i] = c;
      coefWe   = 1'b1;
      coefAddr = 4'(i);
      coefData = c[11:0];
      @(negedge clk);
    end
    coefWe = 1'b0;
  endtask

  task automatic setCfg(int md, int il, int sh, int lo, int hi);
    mode     = 2'(md);
    ilDepth  = 4'(il);
    rndShift = 5'(sh);
    limMin   = lo[15:0];
    limMax   = hi[15:0];
    @(negedge clk);
  endtask

  function automatic int pix(int i, int seed);
    return ((i * 613 + seed * 97 + (i * i) % 211) % 4096) - 2048;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    curReq = "R1";
    doReset();
  endtask

  task automatic t_symLong();
    doReset();
    curReq = "R3 R11 R13";
    loadCoefs(1, 255);
    setCfg(0, 0, 9, -32768, 32767);
    for (int i = 0; i < 48; i++) pushSample(pix(i, 1), 0);
    drain();
  endtask

  task automatic t_symPair();
    doReset();
    curReq = "R4";
    loadCoefs(2, 255);
    setCfg(1, 0, 8, -32768, 32767);
    for (int i = 0; i < 40; i++) pushSample(pix(i, 2), pix(i, 7));
    drain();
  endtask

  task automatic t_asymLongGaps();
    doReset();
    curReq = "R5 R7 R10";
    loadCoefs(3, 255);
    setCfg(2, 2, 8, -32768, 32767);
    for (int i = 0; i < 60; i++) begin
      pushSample(pix(i, 3), pix(i, 9));
      if (i % 3 == 2) idleGap(2);
    end
    drain();
  endtask

  task automatic t_asymPairDeep();
    doReset();
    curReq = "R6 R7";
    loadCoefs(4, 255);
    setCfg(3, 15, 7, -32768, 32767);
    for (int i = 0; i < 140; i++) pushSample(pix(i, 4), pix(i, 11));
    drain();
  endtask

  task automatic t_roundLimit();
    doReset();
    curReq = "R8 R9";
    loadCoefs(5, 600);
    setCfg(0, 3, 12, -300, 450);
    for (int i = 0; i < 140; i++) pushSample(pix(i, 5), 0);
    drain();
  endtask

  task automatic t_roundEdges();
    int vals [8] = '{5, 6, -6, -5, 2, -2, 7, -7};
    doReset();
    curReq = "R8";
    loadFlat(0);
    coefM[0] = 1; coefWe = 1'b1; coefAddr = 4'd0; coefData = 12'd1;
    @(negedge clk);
    coefWe = 1'b0;
    setCfg(2, 0, 2, -32768, 32767);
    foreach (vals[k]) pushSample(vals[k], 0);
    drain();
  endtask

  task automatic t_noWrap();
    doReset();
    curReq = "R12";
    loadFlat(-2048);
    setCfg(2, 0, 0, -32768, 32767);
    for (int i = 0; i < 20; i++) pushSample(-2048, 0);
    drain();
    setCfg(2, 0, 11, -32768, 32767);
    for (int i = 0; i < 20; i++) pushSample(-2048, 0);
    drain();
    doReset();
    curReq = "R12 R3";
    loadFlat(-2048);
    setCfg(0, 0, 13, -32768, 32767);
    for (int i = 0; i < 40; i++) pushSample(-2048, 0);
    drain();
  endtask

  initial begin
    #1 rstN = 1'b0;
    #10 rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_symLong();
    t_symPair();
    t_asymLongGaps();
    t_asymPairDeep();
    t_roundLimit();
    t_roundEdges();
    t_noWrap();
    endRun();
  end

  initial begin
    #(5 * 150000);
    nChk++;
    reportFail("R2", "watchdog expired", cycCnt, 0);
    endRun();
  end

endmodule